// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the sequence of column addresses for a single SDRAM read or write burst. A start strobe captures a starting column, a three-bit length code and an ordering bit; from the next clock on, the block presents one column address per cycle. It raises a marker on the final address of a fixed-length burst and then goes idle.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that contains the starting column. The column bits above that block never change. Sequential ordering counts upward and wraps at the block edge. Interleaved ordering XORs the beat index into the low bits. A full-row burst counts through every column of the row, wraps, and keeps going until a terminate input stops it. A start strobe takes effect on any clock, including one in the middle of a burst, and the new sequence begins at once. A configuration that is not allowed produces an error flag and no addresses.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, last_beat and cfg_err are all 0.
- R2: One clock after a start with an allowed configuration, col_valid is 1 and col_addr equals the captured start_col.
- R3: Sequential ordering (ilv=0) with a burst of N beats (N = 2, 4 or 8): beat b carries low bits (start low bits + b) mod N. For N=4 starting at 2, this gives 2,3,0,1.
- R4: Interleaved ordering (ilv=1) with N beats: beat b carries low bits equal to (start low bits) XOR b. For N=8 starting at 5, this gives 5,4,7,6,1,0,3,2.
- R5: During any burst, the column bits above the low log2(N) bits stay equal to those of start_col.
- R6: Length code 000 issues exactly one beat, col_addr = start_col, whatever the value of ilv.
- R7: Length code 111 with ilv=0 issues start_col, start_col+1, and so on, modulo 2^COL_W. It wraps past the end of the row, never asserts last_beat, and continues until terminated.
- R8: Length codes 100, 101 and 110, and code 111 with ilv=1, give cfg_err=1 and col_valid=0 one clock after the start. cfg_err holds until the next start with an allowed configuration. Codes 000, 001, 010 and 011 mean 1, 2, 4 and 8 beats.
- R9: last_beat is 1 exactly with the final address of a fixed-length burst. col_valid is 0 in the following cycle unless a new start was given.
- R10: A terminate pulse (stop=1, start=0) makes col_valid and last_beat 0 from the next clock.
- R11: A start during a burst abandons the current burst; the next clock shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the present inputs |
| start_col | input | COL_W | Starting column |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | 1 = interleaved ordering, 0 = sequential |
| stop | input | 1 | Terminate the running burst |
| col_valid | output | 1 | col_addr carries a burst address |
| col_addr | output | COL_W | Column address of the present beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | Last start used a forbidden configuration |

## Verification
The bench builds the block with its default COL_W of 8, so a full-row burst is 256 beats long. That makes the wrap from column 255 to column 0 reachable within one test. A directed full-row burst is run for more than one row length and is then terminated. With eight column bits, the random starting columns put every block of 2, 4 and 8 beats at many positions inside the row, which exercises the fixed upper bits for both orderings.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam logic [2:0] LC_ONE  = 3'b000;
  localparam logic [2:0] LC_TWO  = 3'b001;
  localparam logic [2:0] LC_FOUR = 3'b010;
  localparam logic [2:0] LC_EIGHT = 3'b011;
  localparam logic [2:0] LC_ROW  = 3'b111;

  typedef struct packed {
    logic       ok;    // configuration allowed
    logic       row;   // full-row burst
    logic [4:0] lg;    // log2 of block span
  } bcfg_t;
endpackage

// File: rtl/bcs_cfg_dec.sv
module bcs_cfg_dec
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0] len_code,
  input  logic       ilv,
  output bcfg_t      cfg
);
  localparam logic [4:0] ROW_LG = 5'(COL_W);

  always_comb begin
    cfg = '{ok: 1'b0, row: 1'b0, lg: 5'd0};
    unique case (len_code)
      LC_ONE:   cfg = '{ok: 1'b1, row: 1'b0, lg: 5'd0};
      LC_TWO:   cfg = '{ok: 1'b1, row: 1'b0, lg: 5'd1};
      LC_FOUR:  cfg = '{ok: 1'b1, row: 1'b0, lg: 5'd2};
      LC_EIGHT: cfg = '{ok: 1'b1, row: 1'b0, lg: 5'd3};
      LC_ROW:   cfg = '{ok: !ilv, row: 1'b1, lg: ROW_LG};
      default:  cfg = '{ok: 1'b0, row: 1'b0, lg: 5'd0};
    endcase
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [4:0]       lg,
  input  logic             ilv,
  output logic [COL_W-1:0] blk_mask,
  output logic [COL_W-1:0] addr
);
  function automatic logic [COL_W-1:0] span_mask(input logic [4:0] l);
    logic [COL_W-1:0] m;
    m = '0;
    for (int i = 0; i < COL_W; i++)
      if (i < int'(l)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] b0,
                                                input logic [COL_W-1:0] n,
                                                input logic [COL_W-1:0] m,
                                                input logic             x);
    logic [COL_W-1:0] low;
    low = x ? (b0 ^ n) : (b0 + n);
    return (b0 & ~m) | (low & m);
  endfunction

  assign blk_mask = span_mask(lg);
  assign addr     = beat_col(base, beat, blk_mask, ilv);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic             stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             last_beat,
  output logic             cfg_err
);
  bcfg_t            cfg_in;
  logic             act_q, ilv_q, row_q, err_q;
  logic [4:0]       lg_q;
  logic [COL_W-1:0] base_q, beat_q, blk_mask;

  // named events
  logic burst_go, burst_bad, beat_final, term_req;

  bcs_cfg_dec #(.COL_W(COL_W)) u_dec (
    .len_code(len_code), .ilv(ilv), .cfg(cfg_in));

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base(base_q), .beat(beat_q), .lg(lg_q), .ilv(ilv_q),
    .blk_mask(blk_mask), .addr(col_addr));

  assign burst_go   = start && cfg_in.ok;
  assign burst_bad  = start && !cfg_in.ok;
  assign term_req   = stop && !start;
  assign beat_final = act_q && !row_q && (beat_q == blk_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0; err_q <= 1'b0; ilv_q <= 1'b0; row_q <= 1'b0;
      lg_q <= '0; base_q <= '0; beat_q <= '0;
    end else if (start) begin
      act_q  <= cfg_in.ok;
      err_q  <= !cfg_in.ok;
      ilv_q  <= ilv;
      row_q  <= cfg_in.row;
      lg_q   <= cfg_in.lg;
      base_q <= start_col;
      beat_q <= '0;
    end else if (term_req || beat_final) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign col_valid = act_q;
  assign last_beat = beat_final;
  assign cfg_err   = err_q;

  // assertions
  assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_err && col_valid));
  assert_bad_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_bad |=> cfg_err && !col_valid);
  assert_start_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go |=> col_valid && col_addr == $past(start_col));
  assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && !start |=> !col_valid);
  assert_stop_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |=> !col_valid && !last_beat);
  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && $past(col_valid) && !$past(start) |->
      (col_addr & ~blk_mask) == ($past(col_addr) & ~blk_mask));
  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && row_q && $past(col_valid) && !$past(start) |->
      col_addr == COL_W'($past(col_addr) + 1'b1));
  assert_row_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_q && col_valid |-> !last_beat);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int COL_W = 8;
  localparam int ROW = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ilv = 1'b0, stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic col_valid, last_beat, cfg_err;
  logic [COL_W-1:0] col_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .stop(stop), .col_valid(col_valid),
    .col_addr(col_addr), .last_beat(last_beat), .cfg_err(cfg_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected column: block base plus position in block
  function automatic int exp_col(input int col, input int n, input int x, input int b);
    int off = col % n;
    int blk = col - off;
    if (x != 0) return blk + (off ^ b);
    return blk + ((off + b) % n);
  endfunction

  task automatic kick(input int col, input int code, input int x);
    start = 1'b1; start_col = COL_W'(col); len_code = 3'(code); ilv = x[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  // full fixed burst; req names the ordering requirement
  task automatic burst(input int col, input int code, input int x, input string req);
    int n = 1 << code;
    kick(col, code, x);
    for (int b = 0; b < n; b++) begin
      chk(col_valid === 1'b1, "R2", int'(col_valid), 1);
      chk(int'(col_addr) == exp_col(col, n, (n == 1) ? 0 : x, b), req,
          int'(col_addr), exp_col(col, n, (n == 1) ? 0 : x, b));
      chk(last_beat === (b == n - 1), "R9", int'(last_beat), int'(b == n - 1));
      @(negedge clk);
    end
    chk(col_valid === 1'b0, "R9", int'(col_valid), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(col_valid === 1'b0, "R1", int'(col_valid), 0);
    chk(last_beat === 1'b0, "R1", int'(last_beat), 0);
    chk(cfg_err === 1'b0, "R1", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    burst(2, 2, 0, "R3");            // 2,3,0,1
    burst(5, 3, 1, "R4");            // 5,4,7,6,1,0,3,2
    burst(8'hB7, 3, 0, "R5");
    burst(8'h6D, 1, 1, "R5");
    burst(8'h93, 0, 1, "R6");
    burst(8'h93, 0, 0, "R6");

    // full row from 250 through the wrap, then terminate
    kick(250, 7, 0);
    for (int b = 0; b < ROW + 20; b++) begin
      chk(int'(col_addr) == (250 + b) % ROW && col_valid === 1'b1, "R7",
          int'(col_addr), (250 + b) % ROW);
      chk(last_beat === 1'b0, "R7", int'(last_beat), 0);
      if (b == ROW + 19) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    chk(col_valid === 1'b0 && last_beat === 1'b0, "R10", int'(col_valid), 0);

    // terminate a fixed burst mid-way
    kick(16, 3, 0);
    @(negedge clk);
    chk(int'(col_addr) == 17, "R3", int'(col_addr), 17);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(col_valid === 1'b0, "R10", int'(col_valid), 0);

    // forbidden configurations
    for (int c = 4; c < 8; c++) begin
      kick(40, c, (c == 7) ? 1 : 0);
      chk(cfg_err === 1'b1 && col_valid === 1'b0, "R8", int'(cfg_err), 1);
      @(negedge clk);
      chk(cfg_err === 1'b1 && col_valid === 1'b0, "R8", int'(cfg_err), 1);
    end
    burst(9, 1, 0, "R3");
    chk(cfg_err === 1'b0, "R8", int'(cfg_err), 0);

    // restart mid-burst
    kick(5, 3, 1);
    @(negedge clk);
    @(negedge clk);
    chk(int'(col_addr) == 7, "R4", int'(col_addr), 7);
    burst(8'h22, 2, 0, "R11");

    // random fixed bursts
    for (int i = 0; i < 300; i++) begin
      int code = int'($urandom % 4);
      int x = int'($urandom % 2);
      int col = int'($urandom % ROW);
      burst(col, code, x, x ? "R4" : "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule